// File: doc/BRIEF.md
# Overflow Interrupt Timer Pair

This block holds two identical 32-bit up-counters behind one memory-mapped register bus. Software arms a timeout by loading an initial value equal to the all-ones maximum minus the wanted delta and then starting the counter. When the count wraps past all-ones, a sticky pending flag is set, the counter reloads the initial value and counting carries on. Each timer drives its own level interrupt, which is the pending flag gated by an interrupt-enable bit.

A control bit named "hold" stops a timer and keeps its count pinned at the initial value, so software can pause a timer and re-arm it. A per-timer divisor slows the count rate to one step every divisor+1 clocks. The live count can be read at any time without disturbing it. The bus is single-cycle. Writes take effect at the clock edge where the write strobe is high. Read data is combinational from the word address.

Top module: `ovf_timer_pair`

## Requirements
- R1: Word address bit 4 selects the timer (0 is the first timer at byte offset 0x00, 1 is the second at 0x40). Word address bits 3:0 select the register: 0 status, 1 count, 4 control, 8 configuration, 9 divisor, 10 initial value. Divisor and initial value read back all 32 written bits. Control and configuration read back only bits 1:0, and their upper bits read 0.
- R2: After reset every register of both timers reads 0 and both interrupt outputs are low.
- R3: While configuration bit 0 (enable) is 1, control bit 1 (start) is 1 and control bit 0 (hold) is 0, the count rises by one every divisor+1 clocks. The first step lands divisor+1 edges after the edge that wrote start.
- R4: A step taken while the count is 0xFFFFFFFF loads the initial value and sets status bit 0. With initial value 0xFFFFFFFF minus D, the flag therefore sets on the (D+1)-th step and every D+1 steps after that.
- R5: Writing status with bit 0 set clears the flag. Writing it with bit 0 clear leaves the flag alone. An overflow in the same cycle as a clear leaves the flag set.
- R6: Control bit 0 (hold) stops counting, and from the second edge after it is written the count equals the initial value. Writing start with hold clear resumes counting from the initial value.
- R7: Each interrupt output equals that timer's status bit 0 ANDed with configuration bit 1. The flag sets on overflow even when configuration bit 1 is 0.
- R8: With enable 0 the count stays frozen. Configuration 0 keeps the interrupt output low.
- R9: Word offsets 2, 3, 5, 6, 7 and 11 to 15 read 0, and writes to them change nothing. Writes to the count register are ignored.
- R10: Programming or running one timer changes no register or interrupt of the other.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_addr | input | 5 | Word address: timer select and register index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| irq | output | 2 | Level interrupt, one bit per timer |

## Verification
The hardest case to reach from the ports is a status clear that arrives on the exact edge where the counter wraps. Here the flag must stay set, because the new overflow takes priority over the clear. The bench reaches this case with no divisor and an initial value three below the maximum. It counts edges from the start write and times the clear write so that it is captured on the fourth step, the overflow edge. The same arithmetic, count equal to the initial value plus (steps mod (D+1)) where steps is elapsed edges divided by divisor+1, drives a sweep over divisors 0 to 2 and deltas 0 to 3 on both timers, checked on every cycle.

// File: rtl/otmr_pkg.sv
`timescale 1ns/1ps
// Package: shared register indices and bit positions for the overflow timer pair.
// Assumes a 16-word register window per timer.
package otmr_pkg;
    localparam int REG_IDX_W = 4;

    localparam logic [REG_IDX_W-1:0] IDX_STAT = 4'h0;
    localparam logic [REG_IDX_W-1:0] IDX_CNT  = 4'h1;
    localparam logic [REG_IDX_W-1:0] IDX_CTRL = 4'h4;
    localparam logic [REG_IDX_W-1:0] IDX_CFG  = 4'h8;
    localparam logic [REG_IDX_W-1:0] IDX_DIV  = 4'h9;
    localparam logic [REG_IDX_W-1:0] IDX_INIT = 4'hA;

    localparam int BIT_HOLD  = 0;   // control
    localparam int BIT_START = 1;   // control
    localparam int BIT_EN    = 0;   // configuration
    localparam int BIT_IRQEN = 1;   // configuration
    localparam int BIT_FLAG  = 0;   // status

    // True when a register index decodes to a real register.
    function automatic logic idx_mapped(input logic [REG_IDX_W-1:0] idx);
        return (idx == IDX_STAT) || (idx == IDX_CNT) || (idx == IDX_CTRL) ||
               (idx == IDX_CFG)  || (idx == IDX_DIV) || (idx == IDX_INIT);
    endfunction
endpackage

// File: rtl/otmr_prescaler.sv
`timescale 1ns/1ps
// Module: otmr_prescaler
// Emits one step pulse every div_i+1 clocks while run_i is high.
// Its phase counter returns to zero whenever run_i drops.
// Assumes div_i is static while running. If div_i is lowered below the phase,
// the comparison still fires on the next clock.
module otmr_prescaler #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run_i,
    input  logic [W-1:0] div_i,
    output logic         tick_o
);
    logic [W-1:0] phase_q;

    // Step when the phase has reached the divisor.
    assign tick_o = run_i && (phase_q >= div_i);

    // Advance the phase, restarting after each step or when stopped.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i || tick_o) phase_q <= '0;
        else                            phase_q <= phase_q + 1'b1;
    end

    // R3: a nonzero divisor never gives two steps on back-to-back clocks.
    a_r3_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && div_i != '0) |=> (!tick_o || div_i == '0));
endmodule

// File: rtl/otmr_counter.sv
`timescale 1ns/1ps
// Module: otmr_counter
// Up-counter that is pinned to init_i while load_i is high. On a step at
// all-ones it wraps to init_i and pulses ovf_o. Assumes at most one step per clock.
module otmr_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic         tick_i,
    input  logic [W-1:0] init_i,
    output logic [W-1:0] count_o,
    output logic         ovf_o
);
    // Overflow is a step taken from the maximum value.
    assign ovf_o = tick_i && !load_i && (&count_o);

    // Hold at the initial value, wrap to it, or step by one.
    always_ff @(posedge clk) begin
        if (!rst_n)       count_o <= '0;
        else if (load_i)  count_o <= init_i;
        else if (tick_i)  count_o <= (&count_o) ? init_i : count_o + 1'b1;
    end

    // R6: while held, the next count is the initial value.
    a_r6_hold_loads_init: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (count_o == $past(init_i)));
    // R4: a wrap lands on the initial value.
    a_r4_wrap_reload: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |=> (count_o == $past(init_i)));
    // R8: with no step and no hold the count does not move.
    a_r8_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !load_i) |=> $stable(count_o));
endmodule

// File: rtl/otmr_channel.sv
`timescale 1ns/1ps
// Module: otmr_channel
// One complete timer: its register file, prescaler, counter, sticky flag and
// gated interrupt. wr_i is already qualified by the timer select. rdata_o is
// combinational from reg_idx_i and reads zero for unmapped indices.
module otmr_channel
    import otmr_pkg::*;
#(
    parameter int W = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_i,
    input  logic [REG_IDX_W-1:0] reg_idx_i,
    input  logic [W-1:0]         wdata_i,
    output logic [W-1:0]         rdata_o,
    output logic                 irq_o
);
    logic         hold_q, start_q, en_q, irqen_q, flag_q;
    logic [W-1:0] div_q, init_q, count;
    logic         run, tick, ovf;

    // Counting needs enable and start with hold released.
    assign run   = en_q && start_q && !hold_q;
    assign irq_o = flag_q && irqen_q;

    // Capture writes to the control, configuration, divisor and initial registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= 1'b0; start_q <= 1'b0; en_q <= 1'b0; irqen_q <= 1'b0;
            div_q  <= '0;   init_q  <= '0;
        end else if (wr_i) begin
            case (reg_idx_i)
                IDX_CTRL: begin
                    hold_q  <= wdata_i[BIT_HOLD];
                    start_q <= wdata_i[BIT_START];
                end
                IDX_CFG: begin
                    en_q    <= wdata_i[BIT_EN];
                    irqen_q <= wdata_i[BIT_IRQEN];
                end
                IDX_DIV:  div_q  <= wdata_i;
                IDX_INIT: init_q <= wdata_i;
                default: ;
            endcase
        end
    end

    // Sticky pending flag: an overflow wins over a same-cycle clear.
    always_ff @(posedge clk) begin
        if (!rst_n)   flag_q <= 1'b0;
        else if (ovf) flag_q <= 1'b1;
        else if (wr_i && reg_idx_i == IDX_STAT && wdata_i[BIT_FLAG]) flag_q <= 1'b0;
    end

    otmr_prescaler #(.W(W)) u_pre (
        .clk(clk), .rst_n(rst_n), .run_i(run), .div_i(div_q), .tick_o(tick)
    );

    otmr_counter #(.W(W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .load_i(hold_q), .tick_i(tick),
        .init_i(init_q), .count_o(count), .ovf_o(ovf)
    );

    // Read multiplexer over the mapped registers.
    always_comb begin
        rdata_o = '0;
        case (reg_idx_i)
            IDX_STAT: rdata_o[BIT_FLAG] = flag_q;
            IDX_CNT:  rdata_o = count;
            IDX_CTRL: begin
                rdata_o[BIT_HOLD]  = hold_q;
                rdata_o[BIT_START] = start_q;
            end
            IDX_CFG: begin
                rdata_o[BIT_EN]    = en_q;
                rdata_o[BIT_IRQEN] = irqen_q;
            end
            IDX_DIV:  rdata_o = div_q;
            IDX_INIT: rdata_o = init_q;
            default:  rdata_o = '0;
        endcase
    end

    // R4: an overflow leaves the flag set.
    a_r4_ovf_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> flag_q);
    // R4: the flag only rises because of an overflow.
    a_r4_flag_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q) |-> $past(ovf));
    // R5: a clear with no competing overflow drops the flag.
    a_r5_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && reg_idx_i == IDX_STAT && wdata_i[BIT_FLAG] && !ovf) |=> !flag_q);
endmodule

// File: rtl/ovf_timer_pair.sv
`timescale 1ns/1ps
// Module: ovf_timer_pair
// NUM_TIMERS identical overflow timers on one single-cycle word-addressed bus.
// The upper address bits select the timer and the low REG_IDX_W bits select
// the register. Selects beyond NUM_TIMERS are unmapped. Read data is combinational.
module ovf_timer_pair
    import otmr_pkg::*;
#(
    parameter  int NUM_TIMERS = 2,
    parameter  int DATA_W     = 32,
    localparam int SEL_W      = (NUM_TIMERS > 1) ? $clog2(NUM_TIMERS) : 1,
    localparam int ADDR_W     = SEL_W + REG_IDX_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_we,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [DATA_W-1:0]     bus_wdata,
    output logic [DATA_W-1:0]     bus_rdata,
    output logic [NUM_TIMERS-1:0] irq
);
    logic [SEL_W-1:0]     sel;
    logic [REG_IDX_W-1:0] idx;
    logic [DATA_W-1:0]    ch_rdata [NUM_TIMERS];
    logic                 sel_ok;

    assign sel    = bus_addr[ADDR_W-1:REG_IDX_W];
    assign idx    = bus_addr[REG_IDX_W-1:0];
    assign sel_ok = (int'(sel) < NUM_TIMERS);

    // One timer per select value, each written only when addressed.
    for (genvar g = 0; g < NUM_TIMERS; g++) begin : g_tmr
        otmr_channel #(.W(DATA_W)) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_i     (bus_we && sel == SEL_W'(g)),
            .reg_idx_i(idx),
            .wdata_i  (bus_wdata),
            .rdata_o  (ch_rdata[g]),
            .irq_o    (irq[g])
        );
    end

    // Return the addressed timer's data, or zero for a missing timer.
    always_comb begin
        bus_rdata = '0;
        if (sel_ok) bus_rdata = ch_rdata[sel];
    end

    // R9: unmapped register offsets read as zero.
    a_r9_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !idx_mapped(idx) |-> (bus_rdata == '0));
endmodule

// File: tb/sim_ovf_timer_pair.sv
`timescale 1ns/1ps
// Bench: sweeps divisor and delta on both timers and checks count, flag and
// interrupt each cycle against arithmetic. Directed tests follow the sweep.
module sim_ovf_timer_pair;
    import otmr_pkg::*;

    localparam logic [31:0] MAX = 32'hFFFF_FFFF;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        bus_we;
    logic [4:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic [1:0]  irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #2 clk = ~clk;   // 250 MHz

    ovf_timer_pair u0 (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // Write captured on the next rising edge; returns at the following falling edge.
    task automatic wr(input int tm, input logic [3:0] idx, input logic [31:0] v);
        bus_addr = {tm[0], idx}; bus_wdata = v; bus_we = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input int tm, input logic [3:0] idx, output logic [31:0] v);
        bus_addr = {tm[0], idx};
        #1;
        v = bus_rdata;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog act=timeout exp=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, ini, c1;
        int t, p;
        rst_n = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R2: reset state of every register and interrupt
        for (int tm = 0; tm < 2; tm++) begin
            rd(tm, IDX_STAT, v); chk("R2 status", v, 0);
            rd(tm, IDX_CNT,  v); chk("R2 count", v, 0);
            rd(tm, IDX_CTRL, v); chk("R2 control", v, 0);
            rd(tm, IDX_CFG,  v); chk("R2 config", v, 0);
            rd(tm, IDX_DIV,  v); chk("R2 divisor", v, 0);
            rd(tm, IDX_INIT, v); chk("R2 initial", v, 0);
        end
        chk("R2 irq", {30'd0, irq}, 0);

        // R3 R4 R7 R10: sweep divisor 0..2, delta 0..3 on each timer
        for (int tm = 0; tm < 2; tm++) begin
            for (int d = 0; d < 3; d++) begin
                for (int dl = 0; dl < 4; dl++) begin
                    ini = MAX - 32'(dl);
                    wr(tm, IDX_CTRL, 32'h1);
                    wr(tm, IDX_CFG,  32'h3);
                    wr(tm, IDX_DIV,  32'(d));
                    wr(tm, IDX_INIT, ini);
                    rd(tm, IDX_DIV, v);  chk("R1 divisor readback", v, 32'(d));
                    rd(tm, IDX_INIT, v); chk("R1 initial readback", v, ini);
                    wr(tm, IDX_STAT, 32'h1);
                    wr(tm, IDX_CTRL, 32'h2);
                    p = dl + 1;
                    for (int k = 0; k <= 2 * p * (d + 1) + 1; k++) begin
                        t = k / (d + 1);
                        rd(tm, IDX_CNT, v);  chk("R3 count", v, ini + 32'(t % p));
                        rd(tm, IDX_STAT, v); chk("R4 flag", v, (t >= p) ? 1 : 0);
                        chk("R7 irq level", {31'd0, irq[tm]}, (t >= p) ? 1 : 0);
                        chk("R10 other irq", {31'd0, irq[1-tm]}, 0);
                        @(negedge clk);
                    end
                end
            end
            wr(tm, IDX_CTRL, 32'h1);
            wr(tm, IDX_CFG,  32'h0);
            wr(tm, IDX_STAT, 32'h1);
        end

        // R6: hold pauses at the initial value and restart resumes from it
        wr(0, IDX_CTRL, 32'h1); wr(0, IDX_CFG, 32'h1);
        wr(0, IDX_DIV, 32'h0);  wr(0, IDX_INIT, 32'd100);
        wr(0, IDX_CTRL, 32'h2);
        repeat (10) @(negedge clk);
        rd(0, IDX_CNT, v); chk("R3 free count", v, 32'd110);
        wr(0, IDX_CTRL, 32'h1);
        @(negedge clk);
        rd(0, IDX_CNT, v); chk("R6 held at init", v, 32'd100);
        repeat (5) @(negedge clk);
        rd(0, IDX_CNT, v); chk("R6 still held", v, 32'd100);
        wr(0, IDX_CTRL, 32'h2);
        repeat (3) @(negedge clk);
        rd(0, IDX_CNT, v); chk("R6 resume from init", v, 32'd103);

        // R7: flag sets with interrupt disabled, irq follows enable
        wr(0, IDX_CTRL, 32'h1); wr(0, IDX_INIT, MAX - 1);
        wr(0, IDX_CTRL, 32'h2);
        repeat (2) @(negedge clk);
        rd(0, IDX_STAT, v); chk("R7 flag without irq enable", v, 1);
        chk("R7 irq masked", {31'd0, irq[0]}, 0);
        wr(0, IDX_CFG, 32'h3);
        chk("R7 irq after enable", {31'd0, irq[0]}, 1);

        // R8: disable freezes the count and drops irq
        wr(0, IDX_CFG, 32'h0);
        rd(0, IDX_CNT, c1);
        repeat (5) @(negedge clk);
        rd(0, IDX_CNT, v); chk("R8 frozen count", v, c1);
        chk("R8 irq low when disabled", {31'd0, irq[0]}, 0);

        // R9: count writes and unmapped offsets have no effect
        wr(0, IDX_CNT, 32'h1234_5678);
        rd(0, IDX_CNT, v); chk("R9 count write ignored", v, c1);
        wr(0, 4'h2, MAX); wr(0, 4'h7, MAX); wr(0, 4'hF, MAX);
        rd(0, 4'h2, v); chk("R9 offset 2 reads zero", v, 0);
        rd(0, 4'h7, v); chk("R9 offset 7 reads zero", v, 0);
        rd(0, 4'hF, v); chk("R9 offset 15 reads zero", v, 0);
        rd(0, IDX_INIT, v); chk("R9 initial untouched", v, MAX - 1);
        rd(0, IDX_DIV, v);  chk("R9 divisor untouched", v, 0);
        rd(0, IDX_CFG, v);  chk("R9 config untouched", v, 0);

        // R1: control and configuration keep only two bits
        wr(1, IDX_CFG, MAX);
        rd(1, IDX_CFG, v); chk("R1 config mask", v, 32'h3);
        wr(1, IDX_CTRL, 32'hFFFF_FFFC);
        rd(1, IDX_CTRL, v); chk("R1 control mask", v, 0);

        // R5: clear landing on the overflow edge; then plain clears
        wr(1, IDX_CTRL, 32'h1); wr(1, IDX_CFG, 32'h3);
        wr(1, IDX_DIV, 32'h0);  wr(1, IDX_INIT, MAX - 3);
        wr(1, IDX_STAT, 32'h1);
        wr(1, IDX_CTRL, 32'h2);                 // start edge E0
        repeat (3) @(negedge clk);              // after E3
        rd(1, IDX_STAT, v); chk("R4 no flag before wrap", v, 0);
        wr(1, IDX_STAT, 32'h1);                 // clear captured at E4 = overflow
        rd(1, IDX_STAT, v); chk("R5 overflow beats clear", v, 1);
        chk("R5 irq stays high", {31'd0, irq[1]}, 1);
        wr(1, IDX_STAT, 32'h0);                 // E5
        rd(1, IDX_STAT, v); chk("R5 zero write keeps flag", v, 1);
        wr(1, IDX_STAT, 32'h1);                 // E6, next wrap at E8
        rd(1, IDX_STAT, v); chk("R5 clear", v, 0);

        // R10: timer 0 untouched by all of the above
        rd(0, IDX_CNT, v); chk("R10 other count", v, c1);
        rd(0, IDX_STAT, v); chk("R10 other flag", v, 1);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule